// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the software-visible control state of two memory management units: one serving instruction fetch and one serving data accesses. Both units sit behind a single load/store request port. One of two select inputs picks the unit for each request, and the register index is taken from a fixed six-bit field of the request address. Writes pass through a filter whose rules depend on the register and on the unit. Reads return their data one cycle after the request.

Every unit keeps a fault status word, a translation table base/configuration word and a tag-access word. The data unit also keeps a fault address, primary and secondary context identifiers, two watchpoint words and general storage at its other indices. Index 0 is not storage. Reading it returns a tag-target word, built from the unit's tag-access value at the time of the read. Each unit's tag-access value is exported continuously to the TLB block, where it becomes the tag of new entries. Each unit's translation table word is exported continuously as decoded fields.

Top module: `mmu_ctl_regs`

## Requirements
- R1: The register index is address bits [8:3]. No other address bit changes which register an access reaches.
- R2: After reset, every stored register reads as zero, `rvalid_o` is low, and all exported tag and table outputs are zero.
- R3: A read request that takes effect raises `rvalid_o` for exactly one cycle, in the cycle after the request. `rdata_o` carries the read value in that same cycle.
- R4: A read of index 0 returns `{3'b000, T[12:0], 48'h0} | (T >> 22)`, where T is the selected unit's tag-access register. A write to index 0 changes nothing.
- R5: In the instruction unit, writes to indices 1, 2, 4, 7 and 8 are ignored, and those indices read as zero.
- R6: A write to index 3 (fault status) with data bit 0 equal to 1 stores the data. With data bit 0 equal to 0 it stores zero.
- R7: In the data unit, a write to index 3 with data bit 0 equal to 0 also clears index 4 (fault address). Other registers are untouched.
- R8: In the data unit, indices 1 (primary context), 2 (secondary context), 4, 7 (virtual watchpoint), 8 (physical watchpoint) and every other index from 9 to NREG-1 store the written value as plain data. In the instruction unit, indices 9 to NREG-1 also store plain data.
- R9: Index 5 holds the translation table word. Its bits [63:13] appear on the base output, bit 12 on the split output and bits [3:0] on the size output, one cycle after the write.
- R10: Index 6 holds tag access. The written value appears on that unit's tag-access output one cycle after the write.
- R11: A request takes effect only when exactly one select input is high. With both selects high or neither high, nothing is stored and no read response is produced.
- R12: Indices from NREG (default 16) to 63 store nothing and read as zero. They do not alias any lower index.
- R13: The two units are independent. An access to one unit never changes a register of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| isel_i | input | 1 | Selects the instruction unit |
| dsel_i | input | 1 | Selects the data unit |
| addr_i | input | ADDR_W (16) | Request address; bits [8:3] are the index |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid while rvalid_o is high |
| rvalid_o | output | 1 | Read response valid |
| itag_access_o | output | 64 | Instruction unit tag access |
| dtag_access_o | output | 64 | Data unit tag access |
| itsb_base_o | output | 51 | Instruction unit table base, bits [63:13] |
| itsb_split_o | output | 1 | Instruction unit table split flag |
| itsb_size_o | output | 4 | Instruction unit table size field |
| dtsb_base_o | output | 51 | Data unit table base, bits [63:13] |
| dtsb_split_o | output | 1 | Data unit table split flag |
| dtsb_size_o | output | 4 | Data unit table size field |

## Verification
The bench sets the data unit's fault address and a watchpoint, then clears fault status with bit 0 low. The fault address must read back as zero while the watchpoint is kept. A design that skipped the side clear, or cleared the wrong index, fails that read. The read-only indices of the instruction unit are written and read back, which catches a filter that stores them or one applied to the wrong unit. Index 0 is read with a tag-access pattern whose context bits and upper bits are both non-zero, so a swapped shift or mask shows up. Accesses with both selects high, with neither high, and to indices of 16 and above are followed by reads of the indices they could have aliased onto, which exposes truncated index decoding and a missing select check.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
  localparam int XLEN       = 64;
  localparam int IDX_W      = 6;
  localparam int IDX_LSB    = 3;
  localparam int PG_SHIFT   = 13;
  localparam int TSB_BASE_W = XLEN - PG_SHIFT;
  localparam int TSB_SIZE_W = 4;
  localparam int TSB_SPLIT  = 12;
  localparam int TT_CTX_LSB = 48;
  localparam int TT_VA_SHR  = 22;

  localparam int IDX_TTGT = 0;
  localparam int IDX_PCTX = 1;
  localparam int IDX_SCTX = 2;
  localparam int IDX_FSR  = 3;
  localparam int IDX_FAR  = 4;
  localparam int IDX_TSB  = 5;
  localparam int IDX_TACC = 6;
  localparam int IDX_VWP  = 7;
  localparam int IDX_PWP  = 8;

  typedef enum logic {MMU_I = 1'b0, MMU_D = 1'b1} mmu_kind_e;

  typedef struct packed {
    logic             wr;
    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  data;
  } reg_wr_t;

  typedef struct packed {
    logic [TSB_BASE_W-1:0] base;
    logic                  split;
    logic [TSB_SIZE_W-1:0] size;
  } tsb_cfg_t;

  function automatic logic [XLEN-1:0] tag_target(input logic [XLEN-1:0] ta);
    logic [XLEN-1:0] ctx_part;
    ctx_part = '0;
    ctx_part[TT_CTX_LSB +: PG_SHIFT] = ta[PG_SHIFT-1:0];
    return ctx_part | (ta >> TT_VA_SHR);
  endfunction
endpackage

// File: rtl/mmu_wr_filter.sv
module mmu_wr_filter
  import mmu_ctl_pkg::*;
#(
  parameter mmu_kind_e KIND = MMU_D,
  parameter int        NREG = 16,
  localparam int       SEL_W = $clog2(NREG)
) (
  input  reg_wr_t              wr_i,
  output logic [NREG-1:0]      en_o,
  output logic [XLEN-1:0]      data_o,
  output logic                 clr_far_o
);
  logic in_range;
  logic ro_hit;
  logic fsr_clear;

  assign in_range  = (int'(wr_i.idx) < NREG) && (int'(wr_i.idx) != IDX_TTGT);
  assign fsr_clear = (int'(wr_i.idx) == IDX_FSR) && !wr_i.data[0];

  generate
    if (KIND == MMU_I) begin : g_imask
      always_comb begin
        case (int'(wr_i.idx))
          IDX_PCTX, IDX_SCTX, IDX_FAR, IDX_VWP, IDX_PWP: ro_hit = 1'b1;
          default:                                       ro_hit = 1'b0;
        endcase
      end
    end else begin : g_dmask
      assign ro_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    en_o      = '0;
    data_o    = fsr_clear ? '0 : wr_i.data;
    clr_far_o = 1'b0;
    if (wr_i.wr && in_range && !ro_hit) begin
      en_o[wr_i.idx[SEL_W-1:0]] = 1'b1;
      clr_far_o = fsr_clear && (KIND == MMU_D);
    end
  end
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_ctl_pkg::*;
#(
  parameter mmu_kind_e KIND = MMU_D,
  parameter int        NREG = 16,
  localparam int       SEL_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_wr_t          wr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic [XLEN-1:0]  tag_acc_o,
  output tsb_cfg_t         tsb_o
);
  logic [NREG-1:0] en;
  logic [XLEN-1:0] wdata;
  logic            clr_far;
  logic [XLEN-1:0] regs [NREG];

  mmu_wr_filter #(.KIND(KIND), .NREG(NREG)) u_filt (
    .wr_i      (wr_i),
    .en_o      (en),
    .data_o    (wdata),
    .clr_far_o (clr_far)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == IDX_FAR) begin : g_far
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      regs[r] <= '0;
        else if (en[r])   regs[r] <= wdata;
        else if (clr_far) regs[r] <= '0;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    regs[r] <= '0;
        else if (en[r]) regs[r] <= wdata;
      end
    end
  end

  assign tag_acc_o = regs[IDX_TACC];
  assign tsb_o.base  = regs[IDX_TSB][XLEN-1:PG_SHIFT];
  assign tsb_o.split = regs[IDX_TSB][TSB_SPLIT];
  assign tsb_o.size  = regs[IDX_TSB][TSB_SIZE_W-1:0];

  always_comb begin
    if (int'(rd_idx_i) == IDX_TTGT)  rd_data_o = tag_target(regs[IDX_TACC]);
    else if (int'(rd_idx_i) < NREG)  rd_data_o = regs[rd_idx_i[SEL_W-1:0]];
    else                             rd_data_o = '0;
  end
endmodule

// File: rtl/mmu_rd_port.sv
module mmu_rd_port
  import mmu_ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            sel_d_i,
  input  logic [XLEN-1:0] i_data_i,
  input  logic [XLEN-1:0] d_data_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= fire_i;
      if (fire_i) rdata_o <= sel_d_i ? d_data_i : i_data_i;
    end
  end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NREG   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_we_i,
  input  logic                  isel_i,
  input  logic                  dsel_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [XLEN-1:0]       wdata_i,
  output logic [XLEN-1:0]       rdata_o,
  output logic                  rvalid_o,
  output logic [XLEN-1:0]       itag_access_o,
  output logic [XLEN-1:0]       dtag_access_o,
  output logic [TSB_BASE_W-1:0] itsb_base_o,
  output logic                  itsb_split_o,
  output logic [TSB_SIZE_W-1:0] itsb_size_o,
  output logic [TSB_BASE_W-1:0] dtsb_base_o,
  output logic                  dtsb_split_o,
  output logic [TSB_SIZE_W-1:0] dtsb_size_o
);
  localparam int NMMU = 2;

  logic             fire;
  logic [IDX_W-1:0] idx;
  logic             unused_addr;
  logic [NMMU-1:0]  sel;
  reg_wr_t          wr   [NMMU];
  logic [XLEN-1:0]  rd   [NMMU];
  logic [XLEN-1:0]  tacc [NMMU];
  tsb_cfg_t         tsb  [NMMU];

  assign idx         = addr_i[IDX_LSB +: IDX_W];
  assign unused_addr = ^{addr_i[ADDR_W-1:IDX_LSB+IDX_W], addr_i[IDX_LSB-1:0]};
  assign fire        = req_valid_i && (isel_i ^ dsel_i);
  assign sel         = {dsel_i, isel_i};

  for (genvar m = 0; m < NMMU; m++) begin : g_mmu
    assign wr[m].wr   = fire && req_we_i && sel[m];
    assign wr[m].idx  = idx;
    assign wr[m].data = wdata_i;

    mmu_reg_bank #(
      .KIND ((m == 0) ? MMU_I : MMU_D),
      .NREG (NREG)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr[m]),
      .rd_idx_i  (idx),
      .rd_data_o (rd[m]),
      .tag_acc_o (tacc[m]),
      .tsb_o     (tsb[m])
    );
  end

  mmu_rd_port u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire && !req_we_i),
    .sel_d_i  (dsel_i),
    .i_data_i (rd[0]),
    .d_data_i (rd[1]),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign itag_access_o = tacc[0];
  assign dtag_access_o = tacc[1];
  assign itsb_base_o   = tsb[0].base;
  assign itsb_split_o  = tsb[0].split;
  assign itsb_size_o   = tsb[0].size;
  assign dtsb_base_o   = tsb[1].base;
  assign dtsb_split_o  = tsb[1].split;
  assign dtsb_size_o   = tsb[1].size;
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_we_i,
  input logic                  isel_i,
  input logic                  dsel_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [XLEN-1:0]       wdata_i,
  input logic [XLEN-1:0]       rdata_o,
  input logic                  rvalid_o,
  input logic [XLEN-1:0]       itag_access_o,
  input logic [XLEN-1:0]       dtag_access_o
);
  logic             rd_go, d_wr, i_wr;
  logic [IDX_W-1:0] ix;

  assign ix    = addr_i[IDX_LSB +: IDX_W];
  assign rd_go = req_valid_i && !req_we_i && (isel_i ^ dsel_i);
  assign d_wr  = req_valid_i && req_we_i && dsel_i && !isel_i;
  assign i_wr  = req_valid_i && req_we_i && isel_i && !dsel_i;

  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> rvalid_o); // R3

  AST_NO_STRAY_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go |=> !rvalid_o); // R11

  AST_TTGT_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && dsel_i && ix == '0) |=> rdata_o == tag_target($past(dtag_access_o))); // R4

  AST_DTAG_EXPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_wr && int'(ix) == IDX_TACC) |=> dtag_access_o == $past(wdata_i)); // R10

  AST_ITAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(i_wr && int'(ix) == IDX_TACC) |=> $stable(itag_access_o)); // R13
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mmu_ctl_regs_tb_top.sv
module mmu_ctl_regs_tb_top;
  localparam int AW = 16;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, we = 1'b0, isel = 1'b0, dsel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata, itag, dtag;
  logic        rvalid;
  logic [50:0] ibase, dbase;
  logic        isplit, dsplit;
  logic [3:0]  isize, dsize;

  int n_chk = 0;
  int n_fail = 0;
  int salt = 0;
  logic [63:0] mi [NR];
  logic [63:0] md [NR];
  logic [63:0] exp_q [$];
  string       req_q [$];

  always #10 clk = ~clk;

  mmu_ctl_regs #(.ADDR_W(AW), .NREG(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_we_i(we),
    .isel_i(isel), .dsel_i(dsel), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid),
    .itag_access_o(itag), .dtag_access_o(dtag),
    .itsb_base_o(ibase), .itsb_split_o(isplit), .itsb_size_o(isize),
    .dtsb_base_o(dbase), .dtsb_split_o(dsplit), .dtsb_size_o(dsize)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string rq);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] ttgt(input logic [63:0] t);
    logic [63:0] hi;
    hi = {3'b000, t[12:0], 48'h0};
    return hi | {22'h0, t[63:22]};
  endfunction

  function automatic logic [63:0] expect_rd(input bit d, input int ix);
    logic [63:0] t;
    t = d ? md[6] : mi[6];
    if (ix == 0) return ttgt(t);
    if (ix >= NR) return 64'h0;
    return d ? md[ix] : mi[ix];
  endfunction

  // one request per cycle; called right after a falling edge
  task automatic acc(input bit w, input bit is, input bit ds, input int ix,
                     input logic [63:0] d, input string rq);
    salt++;
    vld = 1'b1; we = w; isel = is; dsel = ds; wdata = d;
    addr = {7'(salt * 37), ix[5:0], 3'(salt)};
    if (is ^ ds) begin
      if (!w) begin
        exp_q.push_back(expect_rd(ds, ix));
        req_q.push_back(rq);
      end else if (ix != 0 && ix < NR && !(is && (ix == 1 || ix == 2 || ix == 4 || ix == 7 || ix == 8))) begin
        if (ix == 3 && !d[0]) begin
          if (ds) begin md[3] = '0; md[4] = '0; end
          else mi[3] = '0;
        end else if (ds) md[ix] = d;
        else mi[ix] = d;
      end
    end
    @(negedge clk);
    vld = 1'b0; we = 1'b0; isel = 1'b0; dsel = 1'b0;
  endtask

  // monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11: actual rvalid 1 expected 0 (no read pending)");
      end else begin
        chk(rdata, exp_q.pop_front(), req_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) begin mi[k] = '0; md[k] = '0; end
    repeat (3) @(negedge clk);
    chk({63'h0, rvalid}, 64'h0, "R2 rvalid");
    chk(itag | dtag, 64'h0, "R2 tags");
    chk({12'h0, ibase, isplit}, 64'h0, "R2 itsb");
    rst_n = 1'b1;
    @(negedge clk);
    acc(0, 0, 1, 3, '0, "R2 dfsr");
    acc(0, 1, 0, 5, '0, "R2 itsb rd");

    // data unit plain storage, varied address side bits
    acc(1, 0, 1, 1, 64'h0000_0000_0000_1abc, "R8");
    acc(1, 0, 1, 2, 64'h0000_0000_0000_0777, "R8");
    acc(1, 0, 1, 4, 64'hdead_beef_0000_1000, "R8");
    acc(1, 0, 1, 7, 64'h1234_5678_9abc_def0, "R8");
    acc(1, 0, 1, 8, 64'h0fed_cba9_8765_4321, "R8");
    acc(1, 0, 1, 9, 64'h5555_aaaa_5555_aaaa, "R8");
    acc(1, 0, 1, 15, 64'hffff_0000_ffff_0001, "R8");
    acc(0, 0, 1, 1, '0, "R8 pctx");
    acc(0, 0, 1, 2, '0, "R8 sctx");
    acc(0, 0, 1, 7, '0, "R8 vwp");
    acc(0, 0, 1, 8, '0, "R8 pwp");
    acc(0, 0, 1, 9, '0, "R1 index decode");
    acc(0, 0, 1, 15, '0, "R1 index decode");

    // instruction unit read-only indices
    for (int k = 0; k < 5; k++) begin
      int ro_ix;
      ro_ix = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 4 : (k == 3) ? 7 : 8;
      acc(1, 1, 0, ro_ix, 64'hcafe_f00d_0000_0001 + 64'(k), "R5");
      acc(0, 1, 0, ro_ix, '0, "R5 ignored write");
    end
    acc(1, 1, 0, 9, 64'h0bad_c0de_0000_0009, "R8");
    acc(0, 1, 0, 9, '0, "R8 i plain");
    acc(0, 0, 1, 9, '0, "R13 d untouched");

    // fault status
    acc(1, 0, 1, 3, 64'h0000_0000_0000_00f1, "R6");
    acc(1, 1, 0, 3, 64'h0000_0000_0000_0031, "R6");
    acc(0, 0, 1, 3, '0, "R6 d keep");
    acc(0, 1, 0, 3, '0, "R6 i keep");
    acc(1, 0, 1, 3, 64'hffff_ffff_ffff_fffe, "R7");
    acc(0, 0, 1, 3, '0, "R6 d clear");
    acc(0, 0, 1, 4, '0, "R7 far cleared");
    acc(0, 0, 1, 7, '0, "R7 vwp kept");
    acc(0, 1, 0, 3, '0, "R13 i fsr kept");
    acc(1, 1, 0, 3, 64'h0000_0000_0000_0030, "R6");
    acc(0, 1, 0, 3, '0, "R6 i clear");

    // tag access and tag-target view
    acc(1, 0, 1, 6, 64'hfedc_ba98_7654_3210, "R10");
    chk(dtag, 64'hfedc_ba98_7654_3210, "R10 dtag");
    chk(itag, 64'h0, "R13 itag");
    acc(0, 0, 1, 0, '0, "R4");
    acc(1, 0, 1, 0, 64'h1111_2222_3333_4444, "R4");
    acc(0, 0, 1, 0, '0, "R4 write ignored");
    acc(1, 1, 0, 6, 64'h0000_0400_0000_1fff, "R10");
    chk(itag, 64'h0000_0400_0000_1fff, "R10 itag");
    acc(0, 1, 0, 0, '0, "R4 i");

    // translation table word
    acc(1, 0, 1, 5, 64'habcd_ef01_2345_700a, "R9");
    chk({13'h0, dbase}, {13'h0, 51'h55e6_f780_91a2b}, "R9 base");
    chk({63'h0, dsplit}, 64'h1, "R9 split");
    chk({60'h0, dsize}, 64'ha, "R9 size");
    chk({13'h0, ibase}, 64'h0, "R13 itsb");
    acc(0, 0, 1, 5, '0, "R9 read");

    // select rules
    acc(1, 1, 1, 7, 64'h9999_9999_9999_9999, "R11");
    acc(1, 0, 0, 8, 64'h8888_8888_8888_8888, "R11");
    acc(0, 1, 1, 7, '0, "R11");
    chk({63'h0, rvalid}, 64'h0, "R11 no response");
    acc(0, 0, 1, 7, '0, "R11 both-select write dropped");
    acc(0, 0, 1, 8, '0, "R11 no-select write dropped");

    // out-of-range indices
    acc(1, 0, 1, 20, 64'h7777_0000_0000_0001, "R12");
    acc(1, 0, 1, 63, 64'h7777_0000_0000_0002, "R12");
    acc(0, 0, 1, 20, '0, "R12 reads zero");
    acc(0, 0, 1, 4, '0, "R12 no alias");
    acc(0, 0, 1, 15, '0, "R12 no alias");

    repeat (3) @(negedge clk);
    chk(64'(exp_q.size()), 64'h0, "R3 all responses seen");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule